// File: doc/BRIEF.md
# Prefix-Aware Operand Address Generator

This block sits in the operand stage of a CPU with 16-bit instruction encodings. It forms the effective address of a memory operand, the write-back value for the base register, and the instruction length. It also evaluates the address-forming prefix instructions and keeps their result in a private prefix register. A prefix flag marks that register as live. While the flag is set, the next operand-using instruction takes its address from the prefix register instead of its source register. That instruction consumes the flag.

Instructions enter on a valid/ready stream, with the two register-file read values, the PC and the condition-code word beside them. Results leave on a second valid/ready stream through a single output register. `in_ready` is low while that register holds an unconsumed result, and the upstream source must hold its fields stable until acceptance. Once `out_valid` rises, the result fields do not change until `out_ready` is seen high at a clock edge. Two prefix forms take their value from memory: the direct form reads the inline word at PC+2, and the indirect form reads the word at the source register. These forms first emit their fetch address. They then wait on a fill stream (`fill_valid`/`fill_ready`) for the word, and `in_ready` stays low during the wait.

Top module: `pfx_agen`

## Requirements
- R1: For a memory op (op code 1) or condition-code store (op code 2), the address is the prefix register when the prefix flag is set, and the source register value otherwise.
- R2: In autoincrement mode with no prefix and source register not 15, the source register is written back as its value plus the access size. Size codes 0, 1 and 2 mean 1, 2 and 4 bytes.
- R3: In autoincrement mode with the prefix flag set, the source register is written back with the prefix register value, and no immediate is reported even for source 15.
- R4: Source register 15 with no prefix reports an inline immediate at PC+2 with no address access and no write-back. The length is 2 plus the size rounded up to an even count: 4, 4 and 6 bytes for size codes 0, 1 and 2.
- R5: The quick prefix (op code 3) sets prefix = base + sign-extended 8-bit offset, where the base is the destination register. A base index of 15 uses PC+2. The new prefix value also appears on `out_addr`.
- R6: The scaled-index prefix (op code 4) sets prefix = source + (destination << s), with s = 0, 1 and 2 for size codes 0, 1 and 2. Size code 3 raises `out_illegal` and leaves the flag clear.
- R7: The direct prefix (op code 5) reports a fetch at PC+2 flagged as immediate with length 6. The prefix register is then loaded from the fill word.
- R8: The indirect prefix (op code 6) fetches from the source register. In autoincrement mode it writes back source + 4. The prefix register is then loaded from the fill word.
- R9: The prefix flag is set after a completed prefix instruction. Every other accepted instruction (op code 0 plain, 1, 2, or an illegal index) clears it.
- R10: `out_store_data` is the condition-code word with bit 8, the prefix bit, forced to zero.
- R11: After reset, the prefix flag is 0, `out_valid` is 0 and `in_ready` is 1.
- R12: A result is held stable while `out_ready` is low. `in_ready` is low while the output is full or a fill is pending, and `fill_ready` is high only while a fill is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted at this edge if valid |
| in_op | input | 3 | Operation class code |
| in_src | input | 4 | Source register index |
| in_dst | input | 4 | Destination / base register index |
| in_size | input | 2 | Size code |
| in_autoinc | input | 1 | Autoincrement addressing mode |
| in_off | input | 8 | Quick prefix signed offset |
| in_src_val | input | 32 | Source register value |
| in_dst_val | input | 32 | Destination register value |
| in_pc | input | 32 | Address of the instruction |
| in_ccr | input | 32 | Condition-code word |
| fill_valid | input | 1 | Fetched prefix word present |
| fill_ready | output | 1 | Waiting for the prefix word |
| fill_data | input | 32 | Fetched prefix word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_addr_en | output | 1 | A memory access is made at out_addr |
| out_addr | output | 32 | Effective address or new prefix value |
| out_wb_en | output | 1 | Base register write-back |
| out_wb_reg | output | 4 | Write-back register index |
| out_wb_val | output | 32 | Write-back value |
| out_imm | output | 1 | Inline operand sits at PC+2 |
| out_len | output | 4 | Instruction length in bytes |
| out_illegal | output | 1 | Illegal scale size |
| out_store_data | output | 32 | Condition-code word with prefix bit cleared |
| pfx_active | output | 1 | Prefix flag |

## Verification
Random instruction streams mix every op class with and without a live prefix. The same memory op is therefore tried both ways, which separates the prefix-sourced address and write-back from the register-sourced ones. Directed cases cover each size code with source 15 to separate the three immediate lengths, a quick prefix based on register 15 to separate PC+2 from a register base, and an illegal index size. A prefix followed by an autoincrement access on source 15 shows that the prefix overrides the immediate. Random stalls on `out_ready` and delayed fills test holding and blocking under back-pressure.

// File: rtl/agen_pkg.sv
package agen_pkg;

  typedef enum logic [2:0] {
    AG_PLAIN        = 3'd0,
    AG_MEM          = 3'd1,
    AG_CCR_ST       = 3'd2,
    AG_PFX_QUICK    = 3'd3,
    AG_PFX_INDEX    = 3'd4,
    AG_PFX_DIRECT   = 3'd5,
    AG_PFX_INDIRECT = 3'd6
  } ag_op_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      2'd2:    size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/agen_calc.sv
module agen_calc
  import agen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIDX_W = 4,
  parameter int OFFW   = 8,
  parameter int LENW   = 4,
  parameter int PFX_BIT = 8
) (
  input  logic [2:0]        op,
  input  logic [RIDX_W-1:0] src_idx,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [1:0]        size,
  input  logic              autoinc,
  input  logic [OFFW-1:0]   off,
  input  logic [AW-1:0]     src_val,
  input  logic [AW-1:0]     dst_val,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     ccr,
  input  logic              pfx_flag,
  input  logic [AW-1:0]     pfx_val,
  output logic              addr_en,
  output logic [AW-1:0]     addr,
  output logic              wb_en,
  output logic [AW-1:0]     wb_val,
  output logic              imm,
  output logic [LENW-1:0]   len,
  output logic              illegal,
  output logic              set_now,
  output logic [AW-1:0]     set_val,
  output logic              wait_fill,
  output logic [AW-1:0]     store_data
);

  localparam logic [RIDX_W-1:0] PC_IDX = {RIDX_W{1'b1}};
  localparam logic [AW-1:0]     TWO    = AW'(2);
  localparam logic [AW-1:0]     FOUR   = AW'(4);
  localparam logic [AW-1:0]     PMASK  = ~(AW'(1) << PFX_BIT);
  localparam int                NSCALE = 3;

  logic [2:0]    bytes;
  logic [2:0]    even_bytes;
  logic [AW-1:0] bytes_ext;
  logic [AW-1:0] pc2;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] scaled_opt [NSCALE];
  logic [AW-1:0] scaled;
  logic [AW-1:0] quick_base;

  // One pre-shifted copy of the index per legal scale
  for (genvar k = 0; k < NSCALE; k++) begin : g_scale
    assign scaled_opt[k] = dst_val << k;
  end

  always_comb begin
    case (size)
      2'd0:    scaled = scaled_opt[0];
      2'd1:    scaled = scaled_opt[1];
      default: scaled = scaled_opt[2];
    endcase
  end

  assign bytes      = size_bytes(size);
  assign even_bytes = (bytes + 3'd1) & 3'b110;
  assign bytes_ext  = AW'(bytes);
  assign pc2        = pc + TWO;
  assign off_ext    = {{(AW-OFFW){off[OFFW-1]}}, off};
  assign quick_base = (dst_idx == PC_IDX) ? pc2 : dst_val;
  assign store_data = ccr & PMASK;

  always_comb begin
    addr_en   = 1'b0;
    addr      = '0;
    wb_en     = 1'b0;
    wb_val    = '0;
    imm       = 1'b0;
    len       = LENW'(2);
    illegal   = 1'b0;
    set_now   = 1'b0;
    set_val   = '0;
    wait_fill = 1'b0;
    case (ag_op_e'(op))
      AG_MEM, AG_CCR_ST: begin
        if (pfx_flag) begin
          addr_en = 1'b1;
          addr    = pfx_val;
          wb_en   = autoinc;
          wb_val  = pfx_val;
        end else if (src_idx == PC_IDX) begin
          imm  = 1'b1;
          addr = pc2;
          len  = LENW'(2) + LENW'(even_bytes);
        end else begin
          addr_en = 1'b1;
          addr    = src_val;
          wb_en   = autoinc;
          wb_val  = src_val + bytes_ext;
        end
      end
      AG_PFX_QUICK: begin
        set_now = 1'b1;
        set_val = quick_base + off_ext;
        addr    = set_val;
      end
      AG_PFX_INDEX: begin
        if (size == 2'd3) begin
          illegal = 1'b1;
        end else begin
          set_now = 1'b1;
          set_val = src_val + scaled;
          addr    = set_val;
        end
      end
      AG_PFX_DIRECT: begin
        addr_en   = 1'b1;
        addr      = pc2;
        imm       = 1'b1;
        len       = LENW'(6);
        wait_fill = 1'b1;
      end
      AG_PFX_INDIRECT: begin
        addr_en   = 1'b1;
        addr      = src_val;
        wb_en     = autoinc;
        wb_val    = src_val + FOUR;
        wait_fill = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/agen_pfx_state.sv
module agen_pfx_state #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          set_now,
  input  logic [AW-1:0] set_val,
  input  logic          wait_fill,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_data,
  output logic          fill_ready,
  output logic          busy,
  output logic          flag,
  output logic [AW-1:0] pfx_val
);

  typedef enum logic {PS_IDLE, PS_WAIT} ps_e;
  ps_e state;

  assign fill_ready = (state == PS_WAIT);
  assign busy       = (state == PS_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PS_IDLE;
      flag    <= 1'b0;
      pfx_val <= '0;
    end else if (state == PS_WAIT) begin
      if (fill_valid) begin
        pfx_val <= fill_data;
        flag    <= 1'b1;
        state   <= PS_IDLE;
      end
    end else if (accept) begin
      flag <= set_now;
      if (set_now) pfx_val <= set_val;
      if (wait_fill) state <= PS_WAIT;
    end
  end

  assert_fill_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready |=> flag && pfx_val == $past(fill_data));

  assert_no_accept_wait_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fill_valid |=> busy);

endmodule

// File: rtl/agen_out_stage.sv
module agen_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout));

endmodule

// File: rtl/pfx_agen.sv
module pfx_agen
  import agen_pkg::*;
#(
  parameter int AW      = 32,
  parameter int NREG    = 16,
  parameter int OFFW    = 8,
  parameter int PFX_BIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [2:0]               in_op,
  input  logic [$clog2(NREG)-1:0]  in_src,
  input  logic [$clog2(NREG)-1:0]  in_dst,
  input  logic [1:0]               in_size,
  input  logic                     in_autoinc,
  input  logic [OFFW-1:0]          in_off,
  input  logic [AW-1:0]            in_src_val,
  input  logic [AW-1:0]            in_dst_val,
  input  logic [AW-1:0]            in_pc,
  input  logic [AW-1:0]            in_ccr,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [AW-1:0]            fill_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic                     out_addr_en,
  output logic [AW-1:0]            out_addr,
  output logic                     out_wb_en,
  output logic [$clog2(NREG)-1:0]  out_wb_reg,
  output logic [AW-1:0]            out_wb_val,
  output logic                     out_imm,
  output logic [3:0]               out_len,
  output logic                     out_illegal,
  output logic [AW-1:0]            out_store_data,
  output logic                     pfx_active
);

  localparam int RIDX_W = $clog2(NREG);
  localparam int LENW   = 4;
  localparam int PW     = 1 + AW + 1 + RIDX_W + AW + 1 + LENW + 1 + AW;

  logic            c_addr_en, c_wb_en, c_imm, c_illegal, c_set, c_wait;
  logic [AW-1:0]   c_addr, c_wb_val, c_set_val, c_store;
  logic [LENW-1:0] c_len;
  logic            busy, accept;
  logic [AW-1:0]   pfx_val;
  logic [PW-1:0]   pack_in, pack_out;

  assign in_ready = !busy && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  agen_calc #(
    .AW(AW), .RIDX_W(RIDX_W), .OFFW(OFFW), .LENW(LENW), .PFX_BIT(PFX_BIT)
  ) u_calc (
    .op(in_op), .src_idx(in_src), .dst_idx(in_dst), .size(in_size),
    .autoinc(in_autoinc), .off(in_off), .src_val(in_src_val),
    .dst_val(in_dst_val), .pc(in_pc), .ccr(in_ccr),
    .pfx_flag(pfx_active), .pfx_val(pfx_val),
    .addr_en(c_addr_en), .addr(c_addr), .wb_en(c_wb_en), .wb_val(c_wb_val),
    .imm(c_imm), .len(c_len), .illegal(c_illegal), .set_now(c_set),
    .set_val(c_set_val), .wait_fill(c_wait), .store_data(c_store)
  );

  agen_pfx_state #(.AW(AW)) u_state (
    .clk(clk), .rst_n(rst_n), .accept(accept), .set_now(c_set),
    .set_val(c_set_val), .wait_fill(c_wait), .fill_valid(fill_valid),
    .fill_data(fill_data), .fill_ready(fill_ready), .busy(busy),
    .flag(pfx_active), .pfx_val(pfx_val)
  );

  assign pack_in = {c_addr_en, c_addr, c_wb_en, in_src, c_wb_val,
                    c_imm, c_len, c_illegal, c_store};

  agen_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(pack_in),
    .out_valid(out_valid), .out_ready(out_ready), .dout(pack_out)
  );

  assign {out_addr_en, out_addr, out_wb_en, out_wb_reg, out_wb_val,
          out_imm, out_len, out_illegal, out_store_data} = pack_out;

  assert_flag_quick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 3'(AG_PFX_QUICK) |=> pfx_active);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 3'(AG_PLAIN) |=> !pfx_active);

  assert_wb_pfx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 3'(AG_MEM) && in_autoinc && pfx_active
    |=> out_wb_en && out_wb_val == $past(pfx_val) && !out_imm);

  assert_ccr_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_store_data[PFX_BIT]);

  assert_busy_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |-> !in_ready);

endmodule

// File: tb/sim_pfx_agen.sv
module sim_pfx_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_src = '0, in_dst = '0;
  logic [1:0]  in_size = '0;
  logic        in_autoinc = 1'b0;
  logic [7:0]  in_off = '0;
  logic [31:0] in_src_val = '0, in_dst_val = '0, in_pc = '0, in_ccr = '0;
  logic        fill_valid = 1'b0, fill_ready;
  logic [31:0] fill_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic        out_addr_en, out_wb_en, out_imm, out_illegal, pfx_active;
  logic [31:0] out_addr, out_wb_val, out_store_data;
  logic [3:0]  out_wb_reg, out_len;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_flag = 0;
  logic [31:0] m_pfx = '0;
  logic        e_addr_en, e_wb_en, e_imm, e_ill, e_set, e_wait;
  logic [31:0] e_addr, e_wb_val, e_set_val;
  logic [3:0]  e_len;

  always #4 clk = ~clk;

  pfx_agen u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  task automatic expect_calc(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d,
                             input logic [1:0] sz, input logic ai, input logic [7:0] off,
                             input logic [31:0] sv, input logic [31:0] dv, input logic [31:0] pc);
    e_addr_en = 0; e_addr = 0; e_wb_en = 0; e_wb_val = 0; e_imm = 0;
    e_len = 4'd2; e_ill = 0; e_set = 0; e_set_val = 0; e_wait = 0;
    case (op)
      3'd1, 3'd2: begin
        if (m_flag) begin                       // R1, R3
          e_addr_en = 1; e_addr = m_pfx; e_wb_en = ai; e_wb_val = m_pfx;
        end else if (s == 4'd15) begin          // R4
          e_imm = 1; e_addr = pc + 2;
          e_len = (sz == 2'd2) ? 4'd6 : 4'd4;
        end else begin                          // R1, R2
          e_addr_en = 1; e_addr = sv; e_wb_en = ai; e_wb_val = sv + nbytes(sz);
        end
      end
      3'd3: begin                               // R5
        e_set = 1;
        e_set_val = ((d == 4'd15) ? pc + 2 : dv) + {{24{off[7]}}, off};
        e_addr = e_set_val;
      end
      3'd4: begin                               // R6
        if (sz == 2'd3) e_ill = 1;
        else begin
          e_set = 1; e_set_val = sv + dv * nbytes(sz); e_addr = e_set_val;
        end
      end
      3'd5: begin                               // R7
        e_addr_en = 1; e_addr = pc + 2; e_imm = 1; e_len = 4'd6; e_wait = 1;
      end
      3'd6: begin                               // R8
        e_addr_en = 1; e_addr = sv; e_wb_en = ai; e_wb_val = sv + 4; e_wait = 1;
      end
      default: ;
    endcase
  endtask

  task automatic txn(input logic [2:0] op, input logic [3:0] s, input logic [3:0] d,
                     input logic [1:0] sz, input logic ai, input logic [7:0] off,
                     input logic [31:0] sv, input logic [31:0] dv, input logic [31:0] pc,
                     input logic [31:0] ccr, input int stall, input logic [31:0] fdata);
    logic [31:0] held;
    expect_calc(op, s, d, sz, ai, off, sv, dv, pc);
    @(negedge clk);
    in_op = op; in_src = s; in_dst = d; in_size = sz; in_autoinc = ai; in_off = off;
    in_src_val = sv; in_dst_val = dv; in_pc = pc; in_ccr = ccr; in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R12 out_valid", 32'(out_valid), 32'd1);
    chk("R1 addr", out_addr, e_addr);
    chk("R1 addr_en", 32'(out_addr_en), 32'(e_addr_en));
    chk("R2 wb_en", 32'(out_wb_en), 32'(e_wb_en));
    if (e_wb_en) begin
      chk("R2 wb_val", out_wb_val, e_wb_val);
      chk("R3 wb_reg", 32'(out_wb_reg), 32'(s));
    end
    chk("R4 imm", 32'(out_imm), 32'(e_imm));
    chk("R4 len", 32'(out_len), 32'(e_len));
    chk("R6 illegal", 32'(out_illegal), 32'(e_ill));
    if (op == 3'd2) chk("R10 store", out_store_data, ccr & ~(32'h1 << 8));
    held = out_addr;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R12 hold valid", 32'(out_valid), 32'd1);
      chk("R12 hold addr", out_addr, held);
      chk("R12 in_ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk("R12 drained", 32'(out_valid), 32'd0);
    if (e_wait) begin
      chk("R12 fill_ready", 32'(fill_ready), 32'd1);
      chk("R12 blocked", 32'(in_ready), 32'd0);
      repeat (stall) @(negedge clk);
      fill_valid = 1; fill_data = fdata;
      @(negedge clk);
      fill_valid = 0;
      chk("R12 fill done", 32'(fill_ready), 32'd0);
      m_flag = 1; m_pfx = fdata;
    end else if (e_set) begin
      m_flag = 1; m_pfx = e_set_val;
    end else begin
      m_flag = 0;
    end
    chk("R9 flag", 32'(pfx_active), 32'(m_flag));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R11 flag", 32'(pfx_active), 32'd0);
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11 in_ready", 32'(in_ready), 32'd1);
    // directed: R4 immediate lengths per size
    txn(3'd1, 4'd15, 4'd2, 2'd0, 1, 8'h0, 32'h10, 0, 32'h1000, 0, 0, 0);
    txn(3'd1, 4'd15, 4'd2, 2'd1, 1, 8'h0, 32'h10, 0, 32'h1000, 0, 1, 0);
    txn(3'd1, 4'd15, 4'd2, 2'd2, 0, 8'h0, 32'h10, 0, 32'h1000, 0, 0, 0);
    // R2 autoinc without prefix
    txn(3'd1, 4'd3, 4'd2, 2'd1, 1, 8'h0, 32'h2000, 0, 32'h1000, 0, 0, 0);
    // R5 quick prefix on PC base, negative offset, then R3 prefixed autoinc on src 15
    txn(3'd3, 4'd0, 4'd15, 2'd0, 0, 8'hF0, 0, 32'h55, 32'h4000, 0, 0, 0);
    txn(3'd1, 4'd15, 4'd1, 2'd2, 1, 8'h0, 32'h9, 0, 32'h5000, 0, 2, 0);
    // R6 illegal index size clears flag
    txn(3'd3, 4'd0, 4'd4, 2'd0, 0, 8'h7F, 0, 32'h100, 32'h0, 0, 0, 0);
    txn(3'd4, 4'd1, 4'd2, 2'd3, 0, 8'h0, 32'h100, 32'h3, 0, 0, 0, 0);
    // R6 legal index then R10 ccr store with prefix bit set uses it
    txn(3'd4, 4'd1, 4'd2, 2'd2, 0, 8'h0, 32'h100, 32'h3, 0, 0, 0, 0);
    txn(3'd2, 4'd5, 4'd0, 2'd2, 1, 8'h0, 32'h77, 0, 0, 32'hFFFF_FFFF, 1, 0);
    // R7 direct then R8 indirect prefixes, each consumed by a memory op
    txn(3'd5, 4'd0, 4'd0, 2'd2, 0, 8'h0, 0, 0, 32'h6000, 0, 2, 32'hCAFE_0000);
    txn(3'd1, 4'd7, 4'd0, 2'd0, 0, 8'h0, 32'h1, 0, 0, 0, 0, 0);
    txn(3'd6, 4'd7, 4'd0, 2'd2, 1, 8'h0, 32'h800, 0, 0, 0, 1, 32'hBEEF_0010);
    txn(3'd0, 4'd0, 4'd0, 2'd0, 0, 8'h0, 0, 0, 0, 0, 0, 0);
    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [3:0] s;
      logic [1:0] sz;
      op = 3'($urandom % 7);
      s  = 4'($urandom % 16);
      if (op == 3'd6 && s == 4'd15) s = 4'd3;
      sz = (op == 3'd4) ? 2'($urandom % 4) : 2'($urandom % 3);
      txn(op, s, 4'($urandom % 16), sz, 1'($urandom % 2), 8'($urandom),
          $urandom, $urandom, $urandom & 32'hFFFF_FFFE, $urandom,
          int'($urandom % 3), $urandom);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule